// File: doc/BRIEF.md
# Multidrop Serial Receiver with Standby Wakeup

This block receives asynchronous serial frames on a multidrop line: one low start bit, eight or nine data bits sent least significant bit first, and one high stop bit. A bit-rate sample tick from outside gives sixteen samples per bit. Each bit's value is the majority of samples 7, 8 and 9. Each frame that arrives whole is placed in a data register, and the full flag is raised. A bad stop bit raises a framing flag. A frame that arrives while the previous one has not been taken raises an overrun flag and is dropped.

On a shared line, software can put the receiver in standby with a one-cycle request. While in standby, frames are still decoded for timing but never reach the data register or the status flags. Hardware ends standby by one of two rules, chosen by `wake_sel`. With the first rule, a full idle character on the line ends standby. With the second, a frame whose most significant data bit is 1 ends standby, and that frame is then kept as the first frame of the new message. A second control input chooses whether a run of idle bits is counted from the start bit or only from the stop bit. A single acknowledge input clears all status flags.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, `rdrf`, `idle`, `fe`, `ovr` and `rwu` are 0 and `rx_data` is 0.
- R2: With `mode9`=0 and no standby, an 8-bit frame (start 0, LSB first, stop 1) sets `rdrf`, with the byte in `rx_data[7:0]` and `rx_data[8]`=0. `ack` clears `rdrf`.
- R3: With `mode9`=1, nine data bits are received, and `rx_data[8:0]` holds them LSB first.
- R4: A stop bit that samples as 0 stores the frame and sets both `fe` and `rdrf`. The line must return high before the next start bit is accepted.
- R5: A frame that completes while `rdrf` is 1 sets `ovr` and leaves `rx_data` unchanged.
- R6: An idle character is a run of high samples lasting 10 bit times when `mode9`=0 and 11 bit times when `mode9`=1. Outside standby, `idle` is set once when the line goes idle after a stored frame. It is not set again until another frame is stored.
- R7: With `ilt`=0, idle counting starts right after the start bit. With `ilt`=1, idle counting starts only after the stop bit.
- R8: While `rwu` is 1, completed frames change none of `rdrf`, `rx_data`, `fe` or `ovr`.
- R9: With `wake_sel`=0, an idle character clears `rwu`. That wakeup sets neither `idle` nor `rdrf`, and it does not arm a later `idle`.
- R10: With `wake_sel`=0, pulsing `rwu_set` while the line has already been idle for a full idle character clears `rwu` on the next cycle.
- R11: With `wake_sel`=1, a frame whose top data bit (bit 7, or bit 8 when `mode9`=1) samples as 1 clears `rwu` when that bit is sampled, before its stop bit. The frame is then stored and sets `rdrf`.
- R12: With `wake_sel`=1, idle characters and frames whose top data bit is 0 leave `rwu` at 1.
- R13: A low pulse on `rx` that is high again by mid-bit is rejected as a false start and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle sample strobe at 16x the bit rate |
| rx | input | 1 | Serial line (asynchronous) |
| rwu_set | input | 1 | One-cycle request to enter standby |
| wake_sel | input | 1 | 0: wake on idle line, 1: wake on address-marked frame |
| ilt | input | 1 | 0: idle count from start bit, 1: from stop bit |
| mode9 | input | 1 | 0: eight data bits, 1: nine data bits |
| ack | input | 1 | Clears rdrf, idle, fe and ovr |
| rx_data | output | 9 | Last stored frame's data |
| rdrf | output | 1 | Data register full |
| idle | output | 1 | Line went idle after a received frame |
| fe | output | 1 | Framing error on the stored frame |
| ovr | output | 1 | Frame dropped because rdrf was still set |
| rwu | output | 1 | Standby state |

## Verification
The bench builds the block with its defaults: sixteen samples per bit, a nine-bit data register and a two-stage input synchronizer. It pulses `tick` every fourth clock, so one bit lasts 64 clocks and both idle thresholds, 160 and 176 ticks, are reached within a few hundred clocks. These settings let one run cover both frame lengths, both idle counting origins and both wakeup rules. The windows between the two thresholds, and between the two counting origins, are wide enough for the bench to check an idle flag on each side of its boundary.

// File: rtl/mprx_pkg.sv
package mprx_pkg;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_STOP,
    FR_BREAK
  } fr_state_e;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/mprx_sync.sv
module mprx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  // line idles high, so the chain resets to 1
  always_ff @(posedge clk) begin
    if (rst) sr <= '1;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/mprx_framer.sv
module mprx_framer
  import mprx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxs,
  input  logic          mode9,
  output logic          in_frame,
  output logic          done,
  output logic          stop_ok,
  output logic          msb_hit,
  output logic [DW-1:0] data
);
  localparam int SW = $clog2(OVS);
  localparam int BW = $clog2(DW);
  localparam logic [SW-1:0] VOTE_AT = SW'(OVS / 2);
  localparam logic [SW-1:0] SUB_END = SW'(OVS - 1);
  localparam logic [BW-1:0] LAST_9  = BW'(DW - 1);
  localparam logic [BW-1:0] LAST_8  = BW'(DW - 2);

  fr_state_e     state;
  logic [SW-1:0] sub;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  logic [1:0]    win;
  logic          vote;
  logic          last_bit;

  // majority of the two previous samples and the current one
  assign vote     = vote3({win, rxs});
  assign last_bit = (bitn == (mode9 ? LAST_9 : LAST_8));
  assign in_frame = (state == FR_START) || (state == FR_DATA) || (state == FR_STOP);
  assign data     = mode9 ? shreg : {1'b0, shreg[DW-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= FR_IDLE;
      sub     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      win     <= '1;
      done    <= 1'b0;
      stop_ok <= 1'b1;
      msb_hit <= 1'b0;
    end else begin
      done    <= 1'b0;
      msb_hit <= 1'b0;
      if (tick) begin
        win <= {win[0], rxs};
        unique case (state)
          FR_IDLE: begin
            if (!rxs) begin
              state <= FR_START;
              sub   <= '0;
            end
          end
          FR_START: begin
            sub <= sub + 1'b1;
            if (sub == VOTE_AT && vote) begin
              state <= FR_IDLE;            // false start
            end else if (sub == SUB_END) begin
              state <= FR_DATA;
              sub   <= '0;
              bitn  <= '0;
            end
          end
          FR_DATA: begin
            sub <= sub + 1'b1;
            if (sub == VOTE_AT) begin
              shreg <= {vote, shreg[DW-1:1]};
              if (last_bit) msb_hit <= vote;
            end
            if (sub == SUB_END) begin
              sub <= '0;
              if (last_bit) state <= FR_STOP;
              else          bitn  <= bitn + 1'b1;
            end
          end
          FR_STOP: begin
            sub <= sub + 1'b1;
            if (sub == VOTE_AT) begin
              done    <= 1'b1;
              stop_ok <= vote;
              state   <= vote ? FR_IDLE : FR_BREAK;
            end
          end
          FR_BREAK: begin
            if (rxs) state <= FR_IDLE;
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end

  // a completion strobe never repeats on the next cycle
  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // a frame ending on a low stop bit is followed by the break wait, not a start
  assert_break_after_low_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !stop_ok) |-> (state == FR_BREAK));

endmodule

// File: rtl/mprx_idle_det.sv
module mprx_idle_det #(
  parameter int OVS = 16,
  parameter int DW  = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxs,
  input  logic in_frame,
  input  logic ilt,
  input  logic mode9,
  output logic line_idle
);
  // idle character = start + data + stop bits, all high
  localparam int THR9 = OVS * (DW + 2);
  localparam int THR8 = OVS * (DW + 1);
  localparam int CW   = $clog2(THR9 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;

  assign thr       = mode9 ? CW'(THR9) : CW'(THR8);
  assign line_idle = (cnt >= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      if (!rxs)                cnt <= '0;
      else if (ilt && in_frame) cnt <= '0;
      else if (cnt < thr)      cnt <= cnt + 1'b1;
    end
  end

  // a low sample always drops the idle indication on the next cycle
  assert_low_breaks_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !rxs) |=> !line_idle);

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int OVS         = 16,
  parameter int DW          = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rx,
  input  logic          rwu_set,
  input  logic          wake_sel,
  input  logic          ilt,
  input  logic          mode9,
  input  logic          ack,
  output logic [DW-1:0] rx_data,
  output logic          rdrf,
  output logic          idle,
  output logic          fe,
  output logic          ovr,
  output logic          rwu
);
  logic          rxs;
  logic          in_frame;
  logic          fr_done;
  logic          fr_stop;
  logic          fr_msb;
  logic [DW-1:0] fr_data;
  logic          line_idle;

  logic [DW-1:0] data_q;
  logic          rdrf_q, idle_q, fe_q, ovr_q, rwu_q, seen_q;
  logic          store;

  mprx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx),
    .q   (rxs)
  );

  mprx_framer #(.OVS(OVS), .DW(DW)) i_framer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rxs      (rxs),
    .mode9    (mode9),
    .in_frame (in_frame),
    .done     (fr_done),
    .stop_ok  (fr_stop),
    .msb_hit  (fr_msb),
    .data     (fr_data)
  );

  mprx_idle_det #(.OVS(OVS), .DW(DW)) i_idle (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rxs       (rxs),
    .in_frame  (in_frame),
    .ilt       (ilt),
    .mode9     (mode9),
    .line_idle (line_idle)
  );

  assign store = fr_done && !rwu_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rwu_q  <= 1'b0;
      seen_q <= 1'b0;
      rdrf_q <= 1'b0;
      idle_q <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else begin
      // standby state: software sets, hardware clears
      if (rwu_set)                               rwu_q <= 1'b1;
      else if (rwu_q && !wake_sel && line_idle)  rwu_q <= 1'b0;
      else if (rwu_q &&  wake_sel && fr_msb)     rwu_q <= 1'b0;

      if (ack) begin
        rdrf_q <= 1'b0;
        idle_q <= 1'b0;
        fe_q   <= 1'b0;
        ovr_q  <= 1'b0;
      end

      if (store) begin
        seen_q <= 1'b1;
        if (rdrf_q) begin
          ovr_q <= 1'b1;
        end else begin
          data_q <= fr_data;
          rdrf_q <= 1'b1;
          fe_q   <= !fr_stop;
        end
      end else if (line_idle && seen_q && !(rwu_q && wake_sel)) begin
        // an idle char that ends standby consumes the arming silently
        seen_q <= 1'b0;
        if (!rwu_q) idle_q <= 1'b1;
      end
    end
  end

  assign rx_data = data_q;
  assign rdrf    = rdrf_q;
  assign idle    = idle_q;
  assign fe      = fe_q;
  assign ovr     = ovr_q;
  assign rwu     = rwu_q;

  assert_fe_with_rdrf_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(fe_q) |-> rdrf_q);

  assert_ovr_keeps_data_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_q) |-> $stable(data_q));

  assert_standby_no_store_R8: assert property (@(posedge clk) disable iff (rst)
    (rwu_q && !rdrf_q) |=> !rdrf_q);

  assert_standby_no_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (rwu_q && !idle_q) |=> !idle_q);

  assert_addr_mode_holds_R12: assert property (@(posedge clk) disable iff (rst)
    (rwu_q && wake_sel && !fr_msb) |=> rwu_q);

endmodule

// File: tb/test_mpuart_rx.sv
`timescale 1ns/1ps
module test_mpuart_rx;
  localparam int OVS    = 16;
  localparam int DW     = 9;
  localparam int TDIV   = 4;
  localparam int BITCLK = OVS * TDIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic rx = 1'b1;
  logic rwu_set = 1'b0;
  logic wake_sel = 1'b0;
  logic ilt = 1'b1;
  logic mode9 = 1'b0;
  logic ack = 1'b0;
  logic [DW-1:0] rx_data;
  logic rdrf, idle, fe, ovr, rwu;

  always #2.5 clk = ~clk;

  mpuart_rx #(.OVS(OVS), .DW(DW), .SYNC_STAGES(2)) i_mpuart_rx (
    .clk(clk), .rst(rst), .tick(tick), .rx(rx), .rwu_set(rwu_set),
    .wake_sel(wake_sel), .ilt(ilt), .mode9(mode9), .ack(ack),
    .rx_data(rx_data), .rdrf(rdrf), .idle(idle), .fe(fe), .ovr(ovr), .rwu(rwu)
  );

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural expectation
  int e_rdrf = 0, e_idle = 0, e_fe = 0, e_ovr = 0, e_rwu = 0, e_seen = 0, e_data = 0;
  int pk_rwu = 0, pk_rdrf = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " rdrf"}, int'(rdrf), e_rdrf);
    chk({tag, " data"}, int'(rx_data), e_data);
    chk({tag, " idle"}, int'(idle), e_idle);
    chk({tag, " fe"}, int'(fe), e_fe);
    chk({tag, " ovr"}, int'(ovr), e_ovr);
    chk({tag, " rwu"}, int'(rwu), e_rwu);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_bits(input int n);
    wait_clk(n * BITCLK);
  endtask

  task automatic model_frame(input logic [8:0] d, input bit stop_v);
    bit msb;
    msb = mode9 ? d[8] : d[7];
    if (e_rwu != 0) begin
      if (wake_sel && msb) e_rwu = 0;
      else return;
    end
    e_seen = 1;
    if (e_rdrf != 0) e_ovr = 1;
    else begin
      e_data = mode9 ? int'(d) : int'(d[7:0]);
      e_rdrf = 1;
      e_fe = stop_v ? 0 : 1;
    end
  endtask

  // the line has been idle for a full idle character
  task automatic model_idle();
    if (e_rwu != 0 && !wake_sel) begin
      e_rwu = 0;
      e_seen = 0;
    end else if (e_rwu == 0 && e_seen != 0) begin
      e_idle = 1;
      e_seen = 0;
    end
  endtask

  task automatic do_ack();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
    e_rdrf = 0; e_idle = 0; e_fe = 0; e_ovr = 0;
  endtask

  task automatic do_rwu();
    @(negedge clk) rwu_set = 1'b1;
    @(negedge clk) rwu_set = 1'b0;
    e_rwu = 1;
  endtask

  // start, data LSB first, stop, then one high gap bit
  task automatic send_frame(input logic [8:0] d, input bit stop_v);
    int nb;
    nb = mode9 ? 9 : 8;
    rx = 1'b0;
    wait_bits(1);
    for (int i = 0; i < nb; i++) begin
      rx = d[i];
      wait_bits(1);
    end
    rx = stop_v;
    wait_clk(16);
    pk_rwu = int'(rwu);
    pk_rdrf = int'(rdrf);
    wait_clk(BITCLK - 16);
    rx = 1'b1;
    wait_bits(1);
    model_frame(d, stop_v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    wait_clk(8);
    rst = 1'b0;
    wait_clk(4);
    compare("R1 reset");

    // R2 basic 8-bit frame and R6 single idle flag
    send_frame(9'h0A5, 1'b1);
    compare("R2 frame A5");
    do_ack();
    compare("R2 ack clears");
    wait_bits(12);
    model_idle();
    compare("R6 idle after frame");
    do_ack();
    wait_bits(12);
    model_idle();
    compare("R6 no second idle");

    // R4 framing error, then recovery after line high
    send_frame(9'h03C, 1'b0);
    compare("R4 framing error");
    do_ack();
    send_frame(9'h05A, 1'b1);
    compare("R4 next frame ok");
    do_ack();
    wait_bits(12);
    model_idle();
    do_ack();

    // R5 overrun
    send_frame(9'h011, 1'b1);
    send_frame(9'h022, 1'b1);
    compare("R5 overrun keeps data");
    do_ack();
    wait_bits(12);
    model_idle();
    do_ack();

    // R13 short low glitch
    rx = 1'b0;
    wait_clk(12);
    rx = 1'b1;
    wait_bits(3);
    compare("R13 glitch rejected");
    send_frame(9'h03E, 1'b1);
    compare("R13 frame after glitch");
    do_ack();
    wait_bits(12);
    model_idle();
    do_ack();

    // R10 standby requested on an idle line wakes at once
    do_rwu();
    wait_clk(3);
    model_idle();
    compare("R10 immediate wake");

    // R8 / R9 idle-line wakeup
    send_frame(9'h044, 1'b1);
    do_ack();
    do_rwu();
    send_frame(9'h055, 1'b1);
    send_frame(9'h066, 1'b0);
    compare("R8 standby ignores frames");
    wait_bits(12);
    model_idle();
    compare("R9 idle wake quiet");
    wait_bits(12);
    model_idle();
    compare("R9 no idle after wake");
    send_frame(9'h077, 1'b1);
    compare("R8 normal after wake");
    do_ack();
    wait_bits(12);
    model_idle();
    do_ack();

    // R7 idle counting origin
    ilt = 1'b0;
    send_frame(9'h0FF, 1'b1);
    do_ack();
    wait_bits(2);
    model_idle();
    compare("R7 ilt0 early idle");
    do_ack();
    ilt = 1'b1;
    wait_bits(2);
    send_frame(9'h0FF, 1'b1);
    do_ack();
    wait_bits(2);
    compare("R7 ilt1 not yet idle");
    wait_bits(9);
    model_idle();
    compare("R7 ilt1 idle later");
    do_ack();

    // R3 nine-bit frame and R6 longer idle character
    mode9 = 1'b1;
    send_frame(9'h1C3, 1'b1);
    compare("R3 nine-bit data");
    do_ack();
    wait_bits(9);
    compare("R6 nine-bit idle not reached");
    wait_bits(3);
    model_idle();
    compare("R6 nine-bit idle reached");
    do_ack();

    // R12 / R11 address-mark wakeup, nine-bit
    wake_sel = 1'b1;
    do_rwu();
    wait_clk(3);
    compare("R12 idle line no wake");
    send_frame(9'h0FF, 1'b1);
    compare("R12 data frame ignored");
    wait_bits(15);
    model_idle();
    compare("R12 idle char no wake");
    send_frame(9'h155, 1'b1);
    chk("R11 rwu clear before stop", pk_rwu, 0);
    chk("R11 rdrf not yet at stop", pk_rdrf, 0);
    compare("R11 address frame stored");
    do_ack();

    // R11 address-mark wakeup, eight-bit
    mode9 = 1'b0;
    do_rwu();
    send_frame(9'h07F, 1'b1);
    compare("R12 msb0 frame ignored");
    send_frame(9'h085, 1'b1);
    chk("R11 eight-bit rwu clear before stop", pk_rwu, 0);
    compare("R11 eight-bit address stored");
    do_ack();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule